// File: doc/BRIEF.md
# Accumulator Instruction Cycle Sequencer

This block is the multicycle control unit of a small accumulator machine whose program and data share one read-write memory, reached purely by location. Each instruction is walked through a fixed series of phases: next-address setup, instruction fetch, decode, operand address setup, operand fetch, data operation and result write-back. Phases that an instruction does not need are skipped. Every memory access goes out through an address register and a data buffer register.

At the end of every instruction the sequencer looks at a level-sensitive interrupt request. If interrupts are enabled, it saves the address of the next instruction, masks further requests, pulses an acknowledge for one cycle and continues fetching at a fixed handler address. A return instruction restores the saved address and unmasks requests. The memory is external, synchronous and single-ported, with read data valid one clock after the address. Debug outputs expose the program counter, the instruction register and the accumulator.

Top module: `acc_seq`

## Requirements
- R1: While reset is held and in the first cycle after its release, the program counter, instruction register and accumulator read 0, the write strobe and the acknowledge are low, and interrupts are enabled.
- R2: An instruction word is 16 bits: opcode in bits 15:12, address in bits 11:0. The fetch presents the program counter on the memory address in the second cycle of the instruction. The word returned one clock later lands in the instruction register, and the program counter is one higher from the fourth cycle of the instruction.
- R3: Opcode 1 (load) reads the word at its address in cycle 6 of the instruction. It places that word in the accumulator, visible from cycle 9.
- R4: Opcode 5 (add) reads its operand in the same way and adds it to the accumulator modulo 2^16. The result is visible from cycle 9 of the instruction.
- R5: Opcode 2 (store) drives the write strobe for exactly one cycle, in cycle 6 of the instruction, with its address on the memory address and the accumulator on the write data. No other opcode writes memory.
- R6: Opcode 8 (jump) loads its address into the program counter, visible from cycle 5 of the instruction, without any operand access.
- R7: Load and add take 9 cycles, store takes 7 cycles, and jump, return and undefined opcodes take 5 cycles. The next instruction begins right after them.
- R8: In the last cycle of an instruction, a request with interrupts enabled raises the acknowledge for that one cycle. The address of the next instruction is saved, the program counter reads 0x100 in the following cycle, and interrupts become disabled.
- R9: While interrupts are disabled, a request causes no acknowledge and does not alter the program flow.
- R10: Opcode 9 (return) reloads the program counter with the saved address, visible from cycle 5 of the instruction, and re-enables interrupts. A request still present in that instruction's last cycle is acknowledged.
- R11: An undefined opcode leaves the accumulator and memory unchanged and only advances the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory address (address register) |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (buffer register) |
| mem_rdata | input | 16 | Memory read data, valid one clock after the address |
| irq | input | 1 | Interrupt request, level |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| dbg_pc | output | 12 | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_acc | output | 16 | Accumulator |

## Verification
The hardest situation to reach from the ports is a request that arrives while the handler runs with interrupts masked, and that is then still present when the return instruction re-enables them. The stimulus shapes the request level cycle by cycle against the known instruction lengths. It first raises the request for the first instruction only, then again across the handler's add. In one run the request is dropped before the return; in the other it is held through the return's final cycle, so a second acknowledge appears exactly there. A sweep of operand pairs, including ones that wrap past 16 bits, runs a load, add and store sequence to 0x940 and 0x941 with cycle-exact checks.

// File: rtl/acc_seq.sv
module acc_seq #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter logic [AW-1:0] HANDLER = 'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          irq,
  output logic          irq_ack,
  output logic [AW-1:0] dbg_pc,
  output logic [DW-1:0] dbg_ir,
  output logic [DW-1:0] dbg_acc
);
  localparam int OPW = DW - AW;
  localparam logic [OPW-1:0] OP_LOAD = OPW'(1);
  localparam logic [OPW-1:0] OP_STORE = OPW'(2);
  localparam logic [OPW-1:0] OP_ADD = OPW'(5);
  localparam logic [OPW-1:0] OP_JUMP = OPW'(8);
  localparam logic [OPW-1:0] OP_RET = OPW'(9);

  typedef enum logic [3:0] {
    S_NXT, S_FET, S_FWT, S_DEC, S_OPA, S_OPF, S_OPW, S_EXE, S_STO, S_CHK
  } phase_t;

  phase_t          state;
  logic [AW-1:0]   pc, mar, saved;
  logic [DW-1:0]   ir, mbr, acc;
  logic            ien;
  logic [OPW-1:0]  opc;
  logic [AW-1:0]   opnd;
  logic            take_irq;

  assign opc       = ir[DW-1:AW];
  assign opnd      = ir[AW-1:0];
  assign take_irq  = (state == S_CHK) && irq && ien;
  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = (state == S_STO);
  assign irq_ack   = take_irq;
  assign dbg_pc    = pc;
  assign dbg_ir    = ir;
  assign dbg_acc   = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_NXT;
      pc    <= '0;
      mar   <= '0;
      saved <= '0;
      ir    <= '0;
      mbr   <= '0;
      acc   <= '0;
      ien   <= 1'b1;
    end else begin
      case (state)
        S_NXT: begin
          mar   <= pc;
          state <= S_FET;
        end
        S_FET: state <= S_FWT;
        S_FWT: begin
          ir    <= mem_rdata;
          mbr   <= mem_rdata;
          pc    <= pc + AW'(1);
          state <= S_DEC;
        end
        S_DEC: begin
          case (opc)
            OP_LOAD, OP_ADD, OP_STORE: state <= S_OPA;
            OP_JUMP: begin
              pc    <= opnd;
              state <= S_CHK;
            end
            OP_RET: begin
              pc    <= saved;
              ien   <= 1'b1;
              state <= S_CHK;
            end
            default: state <= S_CHK;
          endcase
        end
        S_OPA: begin
          mar <= opnd;
          if (opc == OP_STORE) begin
            mbr   <= acc;
            state <= S_STO;
          end else begin
            state <= S_OPF;
          end
        end
        S_OPF: state <= S_OPW;
        S_OPW: begin
          mbr   <= mem_rdata;
          state <= S_EXE;
        end
        S_EXE: begin
          if (opc == OP_LOAD) acc <= mbr;
          else acc <= acc + mbr;
          state <= S_CHK;
        end
        S_STO: state <= S_CHK;
        S_CHK: begin
          if (take_irq) begin
            saved <= pc;
            pc    <= HANDLER;
            ien   <= 1'b0;
          end
          state <= S_NXT;
        end
        default: state <= S_NXT;
      endcase
    end
  end

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FWT) |=> (pc == $past(pc) + AW'(1)));
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXE && opc == OP_LOAD) |=> (acc == $past(mbr)));
  p_write_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  p_write_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == acc));
  p_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEC && opc == OP_JUMP) |=> (pc == $past(opnd)));
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);
  p_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (pc == HANDLER && saved == $past(pc)));
  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !ien);
  p_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEC && opc == OP_RET) |=> (ien && pc == $past(saved)));
endmodule

// File: tb/test_acc_seq.sv
`timescale 1ns/1ps
module test_acc_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        irq_ack;
  logic [11:0] dbg_pc;
  logic [15:0] dbg_ir;
  logic [15:0] dbg_acc;

  int nchk = 0;
  int nerr = 0;
  logic [15:0] mem [0:4095];
  logic [11:0] t_addr [1:64];
  logic        t_we   [1:64];
  logic [15:0] t_wd   [1:64];
  logic        t_ack  [1:64];
  logic [11:0] t_pc   [1:64];
  logic [15:0] t_ir   [1:64];
  logic [15:0] t_acc  [1:64];

  always #4 clk = ~clk;

  acc_seq i_acc_seq (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq),
    .irq_ack(irq_ack), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_acc(dbg_acc)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  // irq high in cycles 1..9 and 12..hi_to when irq_mode is set
  task automatic run(input int n, input bit irq_mode, input int hi_to);
    rst_n = 1'b0;
    irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 1; c <= n; c++) begin
      irq = irq_mode && ((c <= 9) || (c >= 12 && c <= hi_to));
      #1;
      t_addr[c] = mem_addr; t_we[c] = mem_we; t_wd[c] = mem_wdata;
      t_ack[c] = irq_ack; t_pc[c] = dbg_pc; t_ir[c] = dbg_ir; t_acc[c] = dbg_acc;
      @(negedge clk);
    end
    irq = 1'b0;
  endtask

  function automatic int count_we(input int n);
    int k = 0;
    for (int c = 1; c <= n; c++) if (t_we[c]) k++;
    return k;
  endfunction

  function automatic int count_ack(input int n);
    int k = 0;
    for (int c = 1; c <= n; c++) if (t_ack[c]) k++;
    return k;
  endfunction

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [15:0] a, b, s;
    // main sweep: LOAD 940, ADD 941, STORE 941, JUMP 3
    for (int i = 0; i < 20; i++) begin
      a = 16'(i * 16'h0fed + 16'h0013);
      b = 16'(16'hffff - i * 16'h1234);
      if (i == 19) begin a = 16'hffff; b = 16'h0001; end
      s = a + b;
      clear_mem();
      mem[0] = 16'h1940; mem[1] = 16'h5941; mem[2] = 16'h2941; mem[3] = 16'h8003;
      mem['h940] = a; mem['h941] = b;
      run(40, 1'b0, 0);
      check("R1 pc", t_pc[1], 0);
      check("R1 acc", t_acc[1], 0);
      check("R1 ir", t_ir[1], 0);
      check("R1 we/ack", {t_we[1], t_ack[1]}, 0);
      check("R2 fetch addr", t_addr[2], 0);
      check("R2 ir", t_ir[4], 16'h1940);
      check("R2 pc inc", t_pc[4], 1);
      check("R3 operand addr", t_addr[6], 12'h940);
      check("R3 load acc", t_acc[9], a);
      check("R7 add fetch addr", t_addr[11], 1);
      check("R4 add acc", t_acc[18], s);
      check("R7 store not early", t_we[23], 0);
      check("R5 store strobe", t_we[24], 1);
      check("R5 store addr", t_addr[24], 12'h941);
      check("R5 store data", t_wd[24], s);
      check("R5 single write", count_we(40), 1);
      check("R5 memory", mem['h941], s);
      check("R6 pc after fetch", t_pc[29], 4);
      check("R6 jump pc", t_pc[30], 3);
      check("R6 refetch addr", t_addr[32], 3);
      check("R9 no ack without irq", count_ack(40), 0);
    end

    // interrupt runs: main LOAD 940, STORE 942, JUMP 2; handler ADD 941, RET
    for (int m = 0; m < 2; m++) begin
      a = 16'h1234 + 16'(m * 16'h0101);
      b = 16'hf00d;
      s = a + b;
      clear_mem();
      mem[0] = 16'h1940; mem[1] = 16'h2942; mem[2] = 16'h8002;
      mem['h100] = 16'h5941; mem['h101] = 16'h9000;
      mem['h940] = a; mem['h941] = b;
      run(40, 1'b1, (m == 0) ? 19 : 23);
      check("R8 no ack before end", t_ack[8], 0);
      check("R8 ack", t_ack[9], 1);
      check("R8 ack pulse", t_ack[10], 0);
      check("R8 vector", t_pc[10], 12'h100);
      check("R8 handler fetch", t_addr[11], 12'h100);
      check("R9 masked", t_ack[18], 0);
      check("R4 handler add", t_acc[18], s);
      check("R10 return pc", t_pc[23], 1);
      if (m == 0) begin
        check("R9 one ack", count_ack(40), 1);
        check("R5 store after return", t_we[29], 1);
        check("R5 store addr", t_addr[29], 12'h942);
        check("R5 memory", mem['h942], s);
      end else begin
        check("R10 re-enabled ack", t_ack[23], 1);
        check("R10 vector again", t_pc[24], 12'h100);
        check("R10 two acks", count_ack(40), 2);
      end
    end

    // undefined opcode then LOAD
    clear_mem();
    mem[0] = 16'h3940; mem[1] = 16'h1940; mem[2] = 16'h8002;
    mem['h940] = 16'h5a5a;
    run(20, 1'b0, 0);
    check("R11 pc advance", t_pc[5], 1);
    check("R11 acc kept", t_acc[5], 0);
    check("R7 next fetch", t_addr[7], 1);
    check("R11 next load", t_acc[14], 16'h5a5a);
    check("R11 no write", count_we(20), 0);
    check("R11 memory kept", mem['h940], 16'h5a5a);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule